// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds in-flight operations for one class of functional unit in a dynamically scheduled core. An operation arrives with a destination register and two source registers. The pool looks each source up in a register result-status table. A source whose register has no pending producer is copied as a value. Otherwise the pool records the number, or tag, of the station that will produce it. The operation then waits in a free station until both operands are present.

Results come back from a single external execution unit and are driven onto a broadcast bus as a data word plus the producing station's tag. The bus carries no destination address. Every waiting station, and every register entry, that is looking for that tag picks up the data. The producing station is released by the same broadcast.

Ready stations are offered to the execution unit one per cycle, lowest index first. Tag 0 means "no producer", and stations are tagged from 1 upward. The register file and the status table live inside the pool. After reset each register holds its own index as its value.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is free (`issue_ready` is 1), and `disp_valid` and `cdb_valid` are 0.
- R2: An issue is taken only in a cycle with `issue_ready` high. When every station is busy, `issue_ready` is 0 and an `issue_valid` pulse leaves no trace: nothing is dispatched or broadcast for it.
- R3: An accepted issue goes to the lowest-indexed free station. The station at index i carries tag i+1, and tag 0 never names a producer.
- R4: A source register with no pending producer supplies its register value. A source register with a pending producer supplies that producer's tag and waits.
- R5: A station is dispatched only when both its producer tags are 0, and it is dispatched exactly once. At most one station is dispatched per cycle, and among ready stations the lowest index goes first. Dispatch outputs are registered: an operation accepted at edge E with ready operands shows on `disp_valid`, `disp_tag`, `disp_a` and `disp_b` after edge E+1.
- R6: A station waiting on a tag equal to the bus tag loads the bus data into that operand and clears its tag.
- R7: The broadcast of a station's tag frees that station at the same edge. `issue_ready` is 1 during that broadcast even when every station is busy, and an issue in that cycle may take the freed station.
- R8: A broadcast whose tag equals a register's status entry writes the data into that register and empties the entry. Later issues read the new value with no wait.
- R9: If an issue names the same destination register in the cycle its pending producer broadcasts, the entry takes the new issue's tag rather than being emptied.
- R10: An issue whose source tag matches the broadcast in the same cycle captures the bus data as a ready operand.
- R11: A result presented on `fu_valid`/`fu_tag`/`fu_data` appears on `cdb_valid`/`cdb_tag`/`cdb_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request |
| issue_op | input | OP_W | Operation code, passed through to the execution unit |
| issue_rd | input | REG_W | Destination register |
| issue_rj | input | REG_W | First source register |
| issue_rk | input | REG_W | Second source register |
| issue_ready | output | 1 | A station is free for an issue this cycle |
| disp_valid | output | 1 | Dispatch to the execution unit this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| disp_op | output | OP_W | Operation code of the dispatched station |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| fu_valid | input | 1 | Execution unit returns a result |
| fu_tag | input | TAG_W | Tag of the returned result |
| fu_data | input | DATA_W | Returned result value |
| cdb_valid | output | 1 | Broadcast bus valid |
| cdb_tag | output | TAG_W | Broadcast bus source tag |
| cdb_data | output | DATA_W | Broadcast bus data |

## Verification
The assertions rely on a well-behaved execution unit. It returns each dispatched tag exactly once, only after the dispatch, never a tag of 0, and at most one result per cycle. Register indices must also stay within the register count. The bench keeps to these rules with an execution-unit model that queues every dispatch it sees and returns results from that queue in order. Returns are either released one at a time on command or let through with random gaps, so the same-cycle broadcast and issue cases are placed on exact edges.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_N_STN  = 3;
  localparam int RS_N_REG  = 8;
  localparam int RS_OP_W   = 4;
  localparam int RS_DATA_W = 64;
  localparam int RS_TAG_W  = 4;

  // station index to producer tag; tag 0 is reserved for "no producer"
  function automatic int tag_of(input int idx);
    return idx + 1;
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // lowest index wins
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
    any = |req;
  end
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int OP_W   = 4,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [DATA_W-1:0] alloc_vj,
  input  logic [TAG_W-1:0]  alloc_qj,
  input  logic [DATA_W-1:0] alloc_vk,
  input  logic [TAG_W-1:0]  alloc_qk,
  input  logic              grant,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  localparam logic [TAG_W-1:0] ID = TAG_W'(MY_TAG);

  logic [TAG_W-1:0] qj, qk;
  logic             sent;
  logic             hit_j, hit_k, hit_me;

  assign hit_j  = cdb_valid && (qj != '0) && (qj == cdb_tag);
  assign hit_k  = cdb_valid && (qk != '0) && (qk == cdb_tag);
  assign hit_me = cdb_valid && (cdb_tag == ID);
  assign ready  = busy && !sent && (qj == '0) && (qk == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sent <= 1'b0;
      op   <= '0;
      vj   <= '0;
      vk   <= '0;
      qj   <= '0;
      qk   <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      sent <= 1'b0;
      op   <= alloc_op;
      vj   <= alloc_vj;
      vk   <= alloc_vk;
      qj   <= alloc_qj;
      qk   <= alloc_qk;
    end else begin
      if (hit_me) begin
        busy <= 1'b0;
        sent <= 1'b0;
      end else if (grant) begin
        sent <= 1'b1;
      end
      if (hit_j) begin
        vj <= cdb_data;
        qj <= '0;
      end
      if (hit_k) begin
        vk <= cdb_data;
        qk <= '0;
      end
    end
  end

  // R5: the picker only grants a station whose operands are both present
  a_r5_grant_needs_operands: assert property (@(posedge clk) disable iff (rst)
    grant |-> (busy && !sent && qj == '0 && qk == '0));

  // R6: snooped operand is captured and its tag cleared
  a_r6_capture_j: assert property (@(posedge clk) disable iff (rst)
    (busy && !alloc && cdb_valid && qj != '0 && qj == cdb_tag)
      |=> (qj == '0 && vj == $past(cdb_data)));
  a_r6_capture_k: assert property (@(posedge clk) disable iff (rst)
    (busy && !alloc && cdb_valid && qk != '0 && qk == cdb_tag)
      |=> (qk == '0 && vk == $past(cdb_data)));

  // R7: own broadcast releases the station
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (busy && !alloc && cdb_valid && cdb_tag == ID) |=> !busy);
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
  parameter int N_REG  = 8,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int REG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  rj,
  input  logic [REG_W-1:0]  rk,
  output logic [DATA_W-1:0] j_val,
  output logic [TAG_W-1:0]  j_tag,
  output logic [DATA_W-1:0] k_val,
  output logic [TAG_W-1:0]  k_tag,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  logic [DATA_W-1:0] regs [N_REG];
  logic [TAG_W-1:0]  stat [N_REG];

  assign j_val = regs[rj];
  assign j_tag = stat[rj];
  assign k_val = regs[rk];
  assign k_tag = stat[rk];

  always_ff @(posedge clk) begin
    for (int r = 0; r < N_REG; r++) begin
      if (rst) begin
        regs[r] <= DATA_W'(r);
        stat[r] <= '0;
      end else begin
        if (cdb_valid && stat[r] != '0 && stat[r] == cdb_tag)
          regs[r] <= cdb_data;
        if (wr_en && wr_reg == REG_W'(r))
          stat[r] <= wr_tag;
        else if (cdb_valid && stat[r] != '0 && stat[r] == cdb_tag)
          stat[r] <= '0;
      end
    end
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_chk
    // R8: matching broadcast writes the register and empties its entry
    a_r8_writeback: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && stat[g] != '0 && stat[g] == cdb_tag
        && !(wr_en && wr_reg == REG_W'(g)))
        |=> (stat[g] == '0 && regs[g] == $past(cdb_data)));
    // R9: a new issue to the register owns the entry
    a_r9_newer_wins: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_reg == REG_W'(g)) |=> (stat[g] == $past(wr_tag)));
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int N_STN  = RS_N_STN,
  parameter int N_REG  = RS_N_REG,
  parameter int OP_W   = RS_OP_W,
  parameter int DATA_W = RS_DATA_W,
  parameter int TAG_W  = RS_TAG_W,
  localparam int REG_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [REG_W-1:0]  issue_rd,
  input  logic [REG_W-1:0]  issue_rj,
  input  logic [REG_W-1:0]  issue_rk,
  output logic              issue_ready,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  input  logic              fu_valid,
  input  logic [TAG_W-1:0]  fu_tag,
  input  logic [DATA_W-1:0] fu_data,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_data
);
  logic [N_STN-1:0]  busy, ready, free_req, alloc_gnt, alloc_vec, disp_gnt;
  logic              any_free, any_ready, issue_fire;
  logic [OP_W-1:0]   st_op [N_STN];
  logic [DATA_W-1:0] st_vj [N_STN];
  logic [DATA_W-1:0] st_vk [N_STN];

  logic [DATA_W-1:0] j_val, k_val, opj_v, opk_v;
  logic [TAG_W-1:0]  j_tag, k_tag, opj_q, opk_q, new_tag;

  logic [TAG_W-1:0]  sel_tag;
  logic [OP_W-1:0]   sel_op;
  logic [DATA_W-1:0] sel_a, sel_b;

  // register file and result-status table
  rs_regstat #(.N_REG(N_REG), .DATA_W(DATA_W), .TAG_W(TAG_W), .REG_W(REG_W)) i_regstat (
    .clk(clk), .rst(rst),
    .rj(issue_rj), .rk(issue_rk),
    .j_val(j_val), .j_tag(j_tag), .k_val(k_val), .k_tag(k_tag),
    .wr_en(issue_fire), .wr_reg(issue_rd), .wr_tag(new_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  // operand resolution, with capture of a broadcast in the issue cycle
  always_comb begin
    if (j_tag == '0) begin
      opj_v = j_val;    opj_q = '0;
    end else if (cdb_valid && cdb_tag == j_tag) begin
      opj_v = cdb_data; opj_q = '0;
    end else begin
      opj_v = '0;       opj_q = j_tag;
    end
    if (k_tag == '0) begin
      opk_v = k_val;    opk_q = '0;
    end else if (cdb_valid && cdb_tag == k_tag) begin
      opk_v = cdb_data; opk_q = '0;
    end else begin
      opk_v = '0;       opk_q = k_tag;
    end
  end

  // allocation: free or being freed by this cycle's broadcast
  rs_pick #(.N(N_STN)) i_alloc_pick (.req(free_req), .gnt(alloc_gnt), .any(any_free));

  assign issue_ready = any_free;
  assign issue_fire  = issue_valid && any_free;

  always_comb begin
    new_tag = '0;
    for (int i = 0; i < N_STN; i++)
      if (alloc_gnt[i]) new_tag = TAG_W'(tag_of(i));
  end

  for (genvar g = 0; g < N_STN; g++) begin : g_stn
    localparam logic [TAG_W-1:0] ID = TAG_W'(tag_of(g));
    assign free_req[g]  = !busy[g] || (cdb_valid && cdb_tag == ID);
    assign alloc_vec[g] = issue_fire && alloc_gnt[g];

    rs_station #(.OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(tag_of(g))) i_stn (
      .clk(clk), .rst(rst),
      .alloc(alloc_vec[g]), .alloc_op(issue_op),
      .alloc_vj(opj_v), .alloc_qj(opj_q), .alloc_vk(opk_v), .alloc_qk(opk_q),
      .grant(disp_gnt[g]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .busy(busy[g]), .ready(ready[g]),
      .op(st_op[g]), .vj(st_vj[g]), .vk(st_vk[g])
    );
  end

  // dispatch: lowest-indexed ready station, one per cycle
  rs_pick #(.N(N_STN)) i_disp_pick (.req(ready), .gnt(disp_gnt), .any(any_ready));

  always_comb begin
    sel_tag = '0;
    sel_op  = '0;
    sel_a   = '0;
    sel_b   = '0;
    for (int i = 0; i < N_STN; i++) begin
      if (disp_gnt[i]) begin
        sel_tag = TAG_W'(tag_of(i));
        sel_op  = st_op[i];
        sel_a   = st_vj[i];
        sel_b   = st_vk[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_tag   <= '0;
      disp_op    <= '0;
      disp_a     <= '0;
      disp_b     <= '0;
    end else begin
      disp_valid <= any_ready;
      if (any_ready) begin
        disp_tag <= sel_tag;
        disp_op  <= sel_op;
        disp_a   <= sel_a;
        disp_b   <= sel_b;
      end
    end
  end

  // broadcast bus driver
  always_ff @(posedge clk) begin
    if (rst) begin
      cdb_valid <= 1'b0;
      cdb_tag   <= '0;
      cdb_data  <= '0;
    end else begin
      cdb_valid <= fu_valid;
      if (fu_valid) begin
        cdb_tag  <= fu_tag;
        cdb_data <= fu_data;
      end
    end
  end

  // R11: returned result reaches the bus one cycle later
  a_r11_bus_forward: assert property (@(posedge clk) disable iff (rst)
    fu_valid |=> (cdb_valid && cdb_tag == $past(fu_tag) && cdb_data == $past(fu_data)));

  // R3: a dispatch always names a real station
  a_r3_disp_tag_range: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (disp_tag != '0 && int'(disp_tag) <= N_STN));

  // R2: a full pool accepts nothing
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (&busy && !cdb_valid) |-> !issue_ready);
endmodule

// File: tb/test_rs_pool.sv
module test_rs_pool;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issue_valid = 1'b0;
  logic [3:0]    issue_op = '0;
  logic [2:0]    issue_rd = '0, issue_rj = '0, issue_rk = '0;
  logic          issue_ready;
  logic          disp_valid;
  logic [TW-1:0] disp_tag;
  logic [3:0]    disp_op;
  logic [DW-1:0] disp_a, disp_b;
  logic          fu_valid = 1'b0;
  logic [TW-1:0] fu_tag = '0;
  logic [DW-1:0] fu_data = '0;
  logic          cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_data;

  rs_pool i_rs_pool (
    .clk(clk), .rst(rst),
    .issue_valid(issue_valid), .issue_op(issue_op), .issue_rd(issue_rd),
    .issue_rj(issue_rj), .issue_rk(issue_rk), .issue_ready(issue_ready),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b),
    .fu_valid(fu_valid), .fu_tag(fu_tag), .fu_data(fu_data),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] mreg [8];
  logic [DW-1:0] exp_q [$];
  logic [TW-1:0] dlog_tag [$];
  logic [DW-1:0] dlog_a [$];
  logic [DW-1:0] dlog_b [$];
  logic [TW-1:0] fuq_tag [$];
  logic [DW-1:0] fuq_dat [$];
  logic [TW-1:0] busq_tag [$];
  logic [DW-1:0] busq_dat [$];
  bit fu_auto = 1'b0;
  int fu_credit = 0;

  function automatic logic [DW-1:0] fu_calc(input logic [3:0] op, input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    case (op)
      4'd0:    return a + b;
      4'd1:    return a - b;
      4'd2:    return a ^ (b << 1);
      default: return a * 5 + b;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // driver: issue once a station is free, push expected result
  task automatic do_issue(input logic [3:0] op, input int rd, input int rj, input int rk);
    logic [DW-1:0] r;
    @(negedge clk);
    while (!issue_ready) @(negedge clk);
    issue_valid = 1'b1; issue_op = op;
    issue_rd = 3'(rd); issue_rj = 3'(rj); issue_rk = 3'(rk);
    r = fu_calc(op, mreg[rj], mreg[rk]);
    mreg[rd] = r;
    exp_q.push_back(r);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  // release one held result, then issue in the cycle it is on the bus
  task automatic release_issue(input logic [3:0] op, input int rd, input int rj, input int rk,
                               input logic [TW-1:0] bus_tag);
    logic [DW-1:0] r;
    @(negedge clk);
    fu_credit++;
    @(negedge clk);
    @(negedge clk);
    check(cdb_valid && cdb_tag == bus_tag, "R11 held result on bus", 64'(cdb_tag), 64'(bus_tag));
    check(issue_ready, "R7 issue_ready during freeing broadcast", 64'(issue_ready), 64'd1);
    issue_valid = 1'b1; issue_op = op;
    issue_rd = 3'(rd); issue_rj = 3'(rj); issue_rk = 3'(rk);
    r = fu_calc(op, mreg[rj], mreg[rk]);
    mreg[rd] = r;
    exp_q.push_back(r);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic wait_idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    dlog_tag.delete(); dlog_a.delete(); dlog_b.delete();
  endtask

  // execution unit model: returns queued results after posedge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && fuq_tag.size() > 0 &&
          ((fu_auto && $urandom_range(0, 2) != 0) || (!fu_auto && fu_credit > 0))) begin
        if (!fu_auto) fu_credit--;
        fu_valid = 1'b1;
        fu_tag   = fuq_tag.pop_front();
        fu_data  = fuq_dat.pop_front();
        busq_tag.push_back(fu_tag);
        busq_dat.push_back(fu_data);
      end else begin
        fu_valid = 1'b0;
      end
    end
  end

  // monitor: log dispatches, compare broadcasts with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (disp_valid) begin
          dlog_tag.push_back(disp_tag);
          dlog_a.push_back(disp_a);
          dlog_b.push_back(disp_b);
          fuq_tag.push_back(disp_tag);
          fuq_dat.push_back(fu_calc(disp_op, disp_a, disp_b));
        end
        if (cdb_valid) begin
          int idx;
          if (busq_tag.size() == 0) begin
            check(1'b0, "R11 broadcast without returned result", 64'(cdb_tag), 64'd0);
          end else begin
            logic [TW-1:0] t;
            logic [DW-1:0] d;
            t = busq_tag.pop_front();
            d = busq_dat.pop_front();
            check(cdb_tag == t && cdb_data == d, "R11 bus carries returned tag and data",
                  cdb_data, d);
          end
          idx = -1;
          for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i] == cdb_data) begin
              idx = i;
              break;
            end
          end
          check(idx >= 0, "R4 R6 R8 R10 broadcast value matches an expected result",
                cdb_data, (exp_q.size() > 0) ? exp_q[0] : '0);
          if (idx >= 0) exp_q.delete(idx);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) mreg[r] = 64'(r);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(issue_ready == 1'b1, "R1 issue_ready after reset", 64'(issue_ready), 64'd1);
    check(disp_valid == 1'b0, "R1 disp_valid after reset", 64'(disp_valid), 64'd0);
    check(cdb_valid == 1'b0, "R1 cdb_valid after reset", 64'(cdb_valid), 64'd0);

    // D1: r1 = r2 + r3 into station tag 1, dispatched after the next edge
    fu_auto = 1'b0;
    do_issue(4'd0, 1, 2, 3);
    check(disp_valid == 1'b0, "R5 no dispatch in the issue cycle", 64'(disp_valid), 64'd0);
    @(negedge clk);
    check(disp_valid == 1'b1, "R5 dispatch one cycle after issue", 64'(disp_valid), 64'd1);
    check(disp_tag == 4'd1, "R3 first station carries tag 1", 64'(disp_tag), 64'd1);
    check(disp_a == 64'd2 && disp_b == 64'd3, "R4 ready sources give register values",
          disp_a, 64'd2);

    // D2: r5 = r1 + r4 waits on tag 1; r6 = r7 + r7 ready; pool then full
    do_issue(4'd0, 5, 1, 4);
    do_issue(4'd0, 6, 7, 7);
    check(issue_ready == 1'b0, "R2 issue_ready low when full", 64'(issue_ready), 64'd0);
    issue_valid = 1'b1; issue_op = 4'd0; issue_rd = 3'd0; issue_rj = 3'd0; issue_rk = 3'd0;
    @(negedge clk);
    issue_valid = 1'b0;
    wait_idle(3);
    check(dlog_tag.size() == 2, "R5 waiting station not dispatched", 64'(dlog_tag.size()), 64'd2);
    if (dlog_tag.size() >= 2)
      check(dlog_tag[1] == 4'd3, "R5 ready younger station dispatched", 64'(dlog_tag[1]), 64'd3);

    // D3: tag 1 broadcasts; new issue reuses station 1 in that cycle
    release_issue(4'd1, 7, 3, 2, 4'd1);
    wait_idle(4);
    check(dlog_tag.size() == 4, "R5 two more dispatches", 64'(dlog_tag.size()), 64'd4);
    if (dlog_tag.size() >= 4) begin
      check(dlog_tag[2] == 4'd1 && dlog_a[2] == 64'd3, "R5 lowest index first (R7 reuse)",
            64'(dlog_tag[2]), 64'd1);
      check(dlog_tag[3] == 4'd2, "R5 next lowest after", 64'(dlog_tag[3]), 64'd2);
      check(dlog_a[3] == 64'd5, "R6 snooped operand value", dlog_a[3], 64'd5);
    end
    fu_auto = 1'b1;
    wait_idle(30);
    check(exp_q.size() == 0, "R2 all results seen and ignored issue absent",
          64'(exp_q.size()), 64'd0);

    // D4: r0 = r5 + r1 after write-back; ready at once
    clear_log();
    do_issue(4'd0, 0, 5, 1);
    @(negedge clk);
    check(disp_valid && disp_tag == 4'd1, "R8 issue after write-back dispatches at once",
          64'(disp_valid), 64'd1);
    check(disp_a == 64'd9 && disp_b == 64'd5, "R8 registers hold broadcast values",
          disp_a, 64'd9);
    wait_idle(20);

    // D5: same-cycle capture and destination overwrite
    fu_auto = 1'b0;
    clear_log();
    do_issue(4'd0, 2, 3, 4);
    wait_idle(3);
    release_issue(4'd0, 2, 2, 2, 4'd1);
    do_issue(4'd0, 3, 2, 0);
    wait_idle(4);
    check(dlog_tag.size() == 2, "R9 consumer waits on newer producer",
          64'(dlog_tag.size()), 64'd2);
    if (dlog_tag.size() >= 2)
      check(dlog_a[1] == 64'd7 && dlog_b[1] == 64'd7, "R10 captured bus value at issue",
            dlog_a[1], 64'd7);
    fu_auto = 1'b1;
    wait_idle(20);
    if (dlog_tag.size() >= 3)
      check(dlog_a[2] == 64'd14, "R9 consumer gets newer result", dlog_a[2], 64'd14);
    else
      check(1'b0, "R9 consumer dispatched", 64'(dlog_tag.size()), 64'd3);

    // random traffic with gaps in returns
    for (int n = 0; n < 400; n++)
      do_issue(4'($urandom_range(0, 3)), $urandom_range(0, 7), $urandom_range(0, 7),
               $urandom_range(0, 7));
    wait_idle(60);
    check(exp_q.size() == 0, "R5 every issued operation dispatched once",
          64'(exp_q.size()), 64'd0);
    check(issue_ready == 1'b1, "R7 all stations released", 64'(issue_ready), 64'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule